// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a processor's reset line in both polarities from a few digitized supply comparators, a software strobe and a pushbutton. All time intervals are counted in units of a single clock-enable tick. Three things can start a reset: the main supply leaving tolerance, a watchdog that the software has stopped strobing, and a debounced pushbutton. Once its cause has gone, a reset stays active for a fixed number of ticks.

A mode input selects how the processor is powered. In volatile mode the processor loses power with the supply, so a supply fault resets it at once and keeps it in reset. In battery-backed mode the processor keeps running from a battery. In that mode a supply fault alone gives no reset. Instead, a reset period starts when the supply rises above the battery level. An early-warning flag (a monitored voltage below its threshold) disables the watchdog, disables the pushbutton and ends any reset that is in progress.

A sleep input lets the processor park the block before it stops. While sleep is set, the watchdog count is frozen, strobe edges are ignored and the early-warning flag is treated as clear. The supply-fault path of volatile mode still works during sleep. All inputs are taken to be synchronous to `clk`.

Top module: `sup_reset_ctl`

## Requirements
- R1: After `rst_n` is released, `cpu_rst` is 0 and `cpu_rst_n` is 1. Every counter is cleared and the debounced button reads released.
- R2: `cpu_rst_n` is always the exact complement of `cpu_rst`.
- R3: In volatile mode (`bat_mode`=0), `vcc_ok`=0 at a clock edge makes `cpu_rst` 1 after that edge, and it stays 1 while `vcc_ok` is 0. After `vcc_ok` returns to 1, reset stays active until RST_TICKS ticks have been sampled. It goes inactive on the edge that samples the last of those ticks.
- R4: The watchdog counts sampled ticks while reset is inactive, `vcc_ok` is 1 and the watchdog is not gated. A strobe falling edge (`strobe` 1 at the previous edge and 0 now) clears the count. On the WD_TICKS-th tick with no strobe edge, a reset period starts at that edge.
- R5: The watchdog count is held at zero while reset is active or `vcc_ok` is 0. It therefore restarts from zero when reset is released.
- R6: The debounced button state changes only after `pb_n` has differed from it for DEB_TICKS consecutive sampled ticks. A shorter excursion has no effect. While the debounced state is pressed (0), reset is held active, and the RST_TICKS period starts at the debounced release.
- R7: In battery-backed mode (`bat_mode`=1), `vcc_ok`=0 starts no reset.
- R8: In battery-backed mode, `ew_low`=1 with `sleep`=0 clears and stops the watchdog and makes the pushbutton have no effect on reset.
- R9: In battery-backed mode, a rising edge of `vcc_gt_bat` starts a reset period. A rising edge means 0 at the previous edge and 1 now; the previous value reads 0 after `rst_n`.
- R10: In battery-backed mode, `ew_low`=1 with `sleep`=0 makes `cpu_rst` 0 after the next edge. This takes priority over every reset source.
- R11: With `sleep`=1, the watchdog count is frozen, strobe edges are ignored and `ew_low` is treated as 0. A volatile-mode supply fault still asserts reset.
- R12: In volatile mode, `ew_low` has no effect on the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Time-base enable, one pulse per time unit |
| bat_mode | input | 1 | 1 = battery-backed processor mode, 0 = volatile mode |
| vcc_ok | input | 1 | Main supply within tolerance |
| ew_low | input | 1 | Early-warning voltage below its threshold |
| vcc_gt_bat | input | 1 | Main supply above battery level |
| strobe | input | 1 | Software keep-alive; a falling edge restarts the watchdog |
| pb_n | input | 1 | Raw pushbutton, active low |
| sleep | input | 1 | Sleep request: freezes watchdog, masks strobe and early warning |
| cpu_rst | output | 1 | Processor reset, active high |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The bound checker checks these rules on every cycle:
- a volatile-mode supply fault asserts reset on the next edge;
- a released reset always ends on a sampled tick or on an early-warning cancel;
- the watchdog count stays below its limit and is zero after any cycle of active reset;
- a battery-mode supply fault alone never raises reset;
- early warning in battery mode cancels reset and clears the watchdog;
- sleep freezes the watchdog count.

Other behaviour depends on a sequence of events and is shown only by the bench's scenarios. This covers the exact length of the hold period, expiry on exactly the WD_TICKS-th unstrobed tick, button glitches shorter than the debounce count being ignored, the power-up pulse in battery mode, and the early-warning input leaving the watchdog untouched in volatile mode. Each of these is compared cycle by cycle against a reference model kept in the bench.

// File: rtl/sup_reset_ctl.sv
module sup_reset_ctl #(
  parameter int RST_TICKS = 100,
  parameter int WD_TICKS  = 400,
  parameter int DEB_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bat_mode,
  input  logic vcc_ok,
  input  logic ew_low,
  input  logic vcc_gt_bat,
  input  logic strobe,
  input  logic pb_n,
  input  logic sleep,
  output logic cpu_rst,
  output logic cpu_rst_n
);
  localparam int HW = $clog2(RST_TICKS + 1);
  localparam int WW = $clog2(WD_TICKS + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam logic [HW-1:0] HOLD_FULL = HW'(RST_TICKS);
  localparam logic [WW-1:0] WD_LAST   = WW'(WD_TICKS - 1);
  localparam logic [DW-1:0] DB_LAST   = DW'(DEB_TICKS - 1);

  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt;
  logic [DW-1:0] db_cnt;
  logic          pb_db;
  logic          strobe_q;
  logic          vgb_q;

  // early warning seen by the block; sleep masks it
  wire ew_eff   = ew_low & ~sleep;
  wire gate_ew  = bat_mode & ew_eff;
  wire st_fall  = strobe_q & ~strobe & ~sleep;
  wire pb_hold  = ~pb_db & ~gate_ew;
  wire pwr_up   = bat_mode & vcc_gt_bat & ~vgb_q;
  wire sup_fail = ~bat_mode & ~vcc_ok;
  wire wd_run   = vcc_ok & ~cpu_rst & ~gate_ew & ~sleep;
  wire wd_exp   = wd_run & tick & ~st_fall & (wd_cnt == WD_LAST);
  wire load     = sup_fail | pb_hold | pwr_up | wd_exp;

  assign cpu_rst   = |hold_cnt;
  assign cpu_rst_n = ~cpu_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      vgb_q    <= 1'b0;
    end else begin
      strobe_q <= strobe;
      vgb_q    <= vcc_gt_bat;
    end
  end

  // reset hold counter: nonzero means reset active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (gate_ew)
      hold_cnt <= '0;
    else if (load)
      hold_cnt <= HOLD_FULL;
    else if (tick && cpu_rst)
      hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wd_cnt <= '0;
    else if (!vcc_ok || cpu_rst || gate_ew)
      wd_cnt <= '0;
    else if (sleep)
      wd_cnt <= wd_cnt;
    else if (st_fall)
      wd_cnt <= '0;
    else if (tick)
      wd_cnt <= (wd_cnt == WD_LAST) ? '0 : wd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_db  <= 1'b1;
      db_cnt <= '0;
    end else if (pb_n == pb_db) begin
      db_cnt <= '0;
    end else if (tick) begin
      if (db_cnt == DB_LAST) begin
        pb_db  <= pb_n;
        db_cnt <= '0;
      end else begin
        db_cnt <= db_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_reset_ctl_chk.sv
module sup_reset_ctl_chk #(
  parameter int WD_TICKS = 400,
  parameter int WW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bat_mode,
  input logic          vcc_ok,
  input logic          ew_low,
  input logic          sleep,
  input logic          cpu_rst,
  input logic [WW-1:0] wd_cnt,
  input logic          pb_hold,
  input logic          pwr_up
);
  AST_VOL_FAIL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bat_mode && !vcc_ok) |=> cpu_rst); // R3
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> ($past(tick) || $past(bat_mode && ew_low && !sleep))); // R3
  AST_WD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wd_cnt) < WD_TICKS); // R4
  AST_WD_ZERO_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |=> (wd_cnt == '0)); // R5
  AST_BAT_NO_FAIL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_mode && !vcc_ok && !cpu_rst && !pb_hold && !pwr_up) |=> !cpu_rst); // R7
  AST_BAT_EW_WD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_mode && ew_low && !sleep) |=> (wd_cnt == '0)); // R8
  AST_BAT_EW_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_mode && ew_low && !sleep) |=> !cpu_rst); // R10
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && vcc_ok && !cpu_rst) |=> (wd_cnt == $past(wd_cnt))); // R11
endmodule

bind sup_reset_ctl sup_reset_ctl_chk #(.WD_TICKS(WD_TICKS), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bat_mode(bat_mode), .vcc_ok(vcc_ok),
  .ew_low(ew_low), .sleep(sleep), .cpu_rst(cpu_rst), .wd_cnt(wd_cnt),
  .pb_hold(pb_hold), .pwr_up(pwr_up)
);

// File: tb/tb_sup_reset_ctl.sv
module tb_sup_reset_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int RST = 5;
  localparam int WD  = 7;
  localparam int DEB = 3;

  logic clk = 1'b0;
  logic rst_n, tick, bat_mode, vcc_ok, ew_low, vcc_gt_bat, strobe, pb_n, sleep;
  logic cpu_rst, cpu_rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_ctl #(.RST_TICKS(RST), .WD_TICKS(WD), .DEB_TICKS(DEB)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bat_mode(bat_mode), .vcc_ok(vcc_ok),
    .ew_low(ew_low), .vcc_gt_bat(vcc_gt_bat), .strobe(strobe), .pb_n(pb_n),
    .sleep(sleep), .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n)
  );

  // reference model built from the requirements
  int m_hold, m_wd, m_dbc;
  bit m_db, m_stq, m_vgbq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_wd = 0; m_dbc = 0; m_db = 1; m_stq = 0; m_vgbq = 0;
    end else begin
      bit g, fall, rv, expd, run;
      int nh, nw;
      g    = bat_mode && ew_low && !sleep;
      fall = m_stq && !strobe && !sleep;
      rv   = (m_hold != 0);
      run  = vcc_ok && !rv && !g && !sleep;
      expd = run && tick && !fall && (m_wd == WD - 1);
      if (g) nh = 0;
      else if ((!bat_mode && !vcc_ok) || (!m_db && !g) ||
               (bat_mode && vcc_gt_bat && !m_vgbq) || expd) nh = RST;
      else if (tick && rv) nh = m_hold - 1;
      else nh = m_hold;
      if (!vcc_ok || rv || g) nw = 0;
      else if (sleep) nw = m_wd;
      else if (fall) nw = 0;
      else if (tick) nw = (m_wd == WD - 1) ? 0 : m_wd + 1;
      else nw = m_wd;
      if (pb_n == m_db) m_dbc = 0;
      else if (tick) begin
        if (m_dbc == DEB - 1) begin m_db = pb_n; m_dbc = 0; end
        else m_dbc = m_dbc + 1;
      end
      m_hold = nh; m_wd = nw; m_stq = strobe; m_vgbq = vcc_gt_bat;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cpu_rst == (m_hold != 0), tag, int'(cpu_rst), int'(m_hold != 0));
    chk(cpu_rst_n == ~cpu_rst, "R2", int'(cpu_rst_n), int'(~cpu_rst));
  endtask

  task automatic settle();
    bat_mode = 0; vcc_ok = 1; ew_low = 0; sleep = 0; pb_n = 1; tick = 1; vcc_gt_bat = 1;
    repeat (RST + DEB + 6) begin strobe = ~strobe; step(); end
  endtask

  initial begin
    rst_n = 0; tick = 0; bat_mode = 0; vcc_ok = 1; ew_low = 0; vcc_gt_bat = 1;
    strobe = 1; pb_n = 1; sleep = 0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(cpu_rst == 0 && cpu_rst_n == 1, "R1", int'(cpu_rst), 0);

    // R3: supply fault and hold length
    tag = "R3"; tick = 1; vcc_ok = 0;
    step();
    chk(cpu_rst == 1, "R3 assert on fault", int'(cpu_rst), 1);
    vcc_ok = 1;
    for (int k = 1; k <= RST; k++) begin
      step();
      if (k == RST - 1) chk(cpu_rst == 1, "R3 still held", int'(cpu_rst), 1);
      if (k == RST)     chk(cpu_rst == 0, "R3 released", int'(cpu_rst), 0);
    end

    // R4 and R5: expiry on the WD-th tick after release
    tag = "R4";
    for (int k = 1; k <= WD; k++) begin
      step();
      if (k == WD - 1) chk(cpu_rst == 0, "R4 before expiry", int'(cpu_rst), 0);
      if (k == WD)     chk(cpu_rst == 1, "R4 expiry", int'(cpu_rst), 1);
    end
    tag = "R5";
    repeat (RST + 2) step();
    tag = "R4";
    repeat (4 * WD) begin strobe = ~strobe; step(); end
    chk(cpu_rst == 0, "R4 strobed watchdog", int'(cpu_rst), 0);

    // R6: debounce
    settle(); tag = "R6";
    pb_n = 0; repeat (DEB - 1) step();
    pb_n = 1; repeat (3) begin strobe = ~strobe; step(); end
    chk(cpu_rst == 0, "R6 glitch ignored", int'(cpu_rst), 0);
    pb_n = 0; repeat (DEB + 4) begin strobe = ~strobe; step(); end
    chk(cpu_rst == 1, "R6 held while pressed", int'(cpu_rst), 1);
    pb_n = 1; repeat (DEB + RST + 2) begin strobe = ~strobe; step(); end
    chk(cpu_rst == 0, "R6 released after period", int'(cpu_rst), 0);

    // R7: battery mode supply fault
    settle(); tag = "R7";
    bat_mode = 1; vcc_ok = 0;
    repeat (3 * WD) step();
    chk(cpu_rst == 0, "R7 no reset on fault", int'(cpu_rst), 0);

    // R9: power-up pulse
    tag = "R9"; vcc_ok = 1; vcc_gt_bat = 0;
    step();
    vcc_gt_bat = 1;
    step();
    chk(cpu_rst == 1, "R9 power-up reset", int'(cpu_rst), 1);

    // R10: early warning cancels reset
    tag = "R10"; ew_low = 1;
    step();
    chk(cpu_rst == 0, "R10 cancel", int'(cpu_rst), 0);

    // R8: watchdog and button gated by early warning
    tag = "R8";
    begin
      bit saw = 0;
      repeat (3 * WD) begin step(); saw |= cpu_rst; end
      pb_n = 0;
      repeat (DEB + 5) begin step(); saw |= cpu_rst; end
      chk(saw == 0, "R8 gated watchdog and button", int'(saw), 0);
      pb_n = 1;
      repeat (DEB + 2) step();
    end

    // R12: volatile mode ignores early warning for the watchdog
    settle(); tag = "R12"; ew_low = 1;
    begin
      bit saw = 0;
      repeat (WD + 2) begin step(); saw |= cpu_rst; end
      chk(saw == 1, "R12 watchdog still expires", int'(saw), 1);
    end

    // R11: sleep freezes watchdog, supply path unmasked
    settle(); tag = "R11"; sleep = 1;
    begin
      bit saw = 0;
      repeat (3 * WD) begin strobe = ~strobe; step(); saw |= cpu_rst; end
      chk(saw == 0, "R11 frozen watchdog", int'(saw), 0);
    end
    vcc_ok = 0;
    step();
    chk(cpu_rst == 1, "R11 supply fault during sleep", int'(cpu_rst), 1);

    // constrained random mix
    settle(); tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      if ($urandom % 3 == 0)   strobe     = ~strobe;
      if ($urandom % 10 == 0)  pb_n       = ~pb_n;
      if ($urandom % 40 == 0)  vcc_ok     = ~vcc_ok;
      if ($urandom % 30 == 0)  ew_low     = ~ew_low;
      if ($urandom % 50 == 0)  vcc_gt_bat = ~vcc_gt_bat;
      if ($urandom % 60 == 0)  sleep      = ~sleep;
      if ($urandom % 200 == 0) bat_mode   = ~bat_mode;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule